// File: doc/BRIEF.md
# Passive LCD Strobe and Bias Timing Generator

This block derives every timing strobe a passive monochrome or grayscale LCD panel needs from one fast reference clock. A programmable divider turns the reference clock into a one-cycle pixel strobe. A pixel counter and a line counter walk the raster. After the last pixel of each line the block spends one pixel period on a line pulse. The frame pulse marks the line pulse of the first line of each frame. A separate divider counts line pulses and toggles the AC bias output so that the liquid crystal never sees a DC level.

The pixel shift period right after each line pulse is stretched by half a period, which reproduces the doubled low phase of the shift clock. A pixel prescale of zero is treated as a stop: no strobe of any kind is made until a non-zero value arrives. The prescale values, width and height are captured only at the end of a frame, while the block is disabled, or while it is stopped. A running frame therefore never sees a period of mixed length.

Top module: `lcd_timing_gen`

## Requirements
- R1: With active pixel prescale N (N >= 1), pix_stb is a one-cycle pulse, and consecutive strobes inside a line are exactly N+1 clock cycles apart.
- R2: While the active pixel prescale is 0, pix_stb, line_pls and frame_pls stay low. When a non-zero value N is then applied, the first strobe appears N+2 cycles later: one cycle to capture the value and N+1 cycles to count.
- R3: The first pixel after each line pulse lasts N+1+floor((N+1)/2) cycles, counted from the cycle in which line_pls falls to the next strobe.
- R4: line_pls rises in the same cycle as the strobe of the last (width-th) pixel of a line and stays high for exactly N+1 cycles.
- R5: frame_pls is high only while line_pls is high, and only during the line pulse of line 0 of each frame, that is, every height-th line pulse starting with the first.
- R6: With bias prescale n (0 to 31), bias_m toggles once every n+1 line pulses, at the cycle in which the line pulse ends. Counting continues across frame boundaries.
- R7: A change of pix_pre, ac_pre, h_pixels or v_lines while running takes effect only at the end of the last line pulse of the current frame. The pixel periods of the rest of that frame keep the old length.
- R8: While rst is high or en is low, all four outputs are low and all counters are cleared. After en rises with N >= 1, the first strobe appears N+1 cycles later and is not stretched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low clears the raster |
| pix_pre | input | 6 | Pixel prescale N; pixel rate = clk/(N+1); 0 stops |
| ac_pre | input | 5 | Bias prescale n; bias_m toggles every n+1 line pulses |
| h_pixels | input | 10 | Pixels per line (1 or more) |
| v_lines | input | 9 | Lines per frame (1 or more) |
| pix_stb | output | 1 | One-cycle pixel shift strobe |
| line_pls | output | 1 | Line pulse, one pixel period long |
| frame_pls | output | 1 | Frame marker during the first line pulse |
| bias_m | output | 1 | AC bias toggle output |

## Verification
The hardest case to reach from the ports is a prescale change that lands in the middle of a frame. The old period must hold through the final line pulse, while the stretched first pixel of the next frame already uses the new length. The bench reaches this case by writing a new prescale a few cycles into a short two-line frame. Its expected period switches only when it sees the last line pulse of that frame fall. A bias prescale of zero, where the bias output flips on every line pulse including those at frame ends, is driven as a separate pass.

// File: rtl/lcd_tg_pkg.sv
`timescale 1ns/1ps
package lcd_tg_pkg;
  // Length of one pixel period, extended by half when it follows a line pulse.
  function automatic int unsigned stretch_len(int unsigned base, bit ext);
    return ext ? base + (base >> 1) : base;
  endfunction
endpackage

// File: rtl/lcd_pix_div.sv
`timescale 1ns/1ps
module lcd_pix_div #(
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [PW-1:0] pre,
  input  logic          stretch,
  output logic          tick
);
  localparam int LW = PW + 1;

  logic [LW-1:0] cnt;
  logic [LW-1:0] len;

  assign len  = LW'(lcd_tg_pkg::stretch_len(32'(pre) + 32'd1, stretch));
  assign tick = !clr && (cnt == len - LW'(1));

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + LW'(1);
  end

  // R1: the period counter never runs past the selected length
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst || clr)
    cnt < len);
endmodule

// File: rtl/lcd_raster.sv
`timescale 1ns/1ps
module lcd_raster #(
  parameter int XW = 10,
  parameter int YW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  input  logic [XW-1:0] width,
  input  logic [YW-1:0] height,
  output logic          pix_stb,
  output logic          line_pls,
  output logic          frame_pls,
  output logic          stretch,
  output logic          line_done,
  output logic          frame_done
);
  logic [XW-1:0] px;
  logic [YW-1:0] ln;

  assign line_done  = tick && line_pls;
  assign frame_done = line_done && (ln == height - YW'(1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      px        <= '0;
      ln        <= '0;
      pix_stb   <= 1'b0;
      line_pls  <= 1'b0;
      frame_pls <= 1'b0;
      stretch   <= 1'b0;
    end else begin
      pix_stb <= tick && !line_pls;
      if (tick && !line_pls) begin
        stretch <= 1'b0;
        if (px == width - XW'(1)) begin
          px        <= '0;
          line_pls  <= 1'b1;
          frame_pls <= (ln == '0);
        end else begin
          px <= px + XW'(1);
        end
      end else if (line_done) begin
        line_pls  <= 1'b0;
        frame_pls <= 1'b0;
        stretch   <= 1'b1;
        ln        <= frame_done ? '0 : ln + YW'(1);
      end
    end
  end

  // R4: a line pulse starts together with the last pixel strobe
  p_line_with_stb_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(line_pls) |-> pix_stb);
  // R5: frame marker lives inside a line pulse
  p_frame_in_line_r5: assert property (@(posedge clk) disable iff (rst)
    frame_pls |-> line_pls);
  // R3: the stretched period only follows a finished line pulse
  p_stretch_after_line_r3: assert property (@(posedge clk) disable iff (rst)
    stretch |-> !line_pls);
endmodule

// File: rtl/lcd_bias.sv
`timescale 1ns/1ps
module lcd_bias #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          line_done,
  input  logic [AW-1:0] ac_pre,
  output logic          m
);
  logic [AW-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc <= '0;
      m   <= 1'b0;
    end else if (line_done) begin
      if (acc == ac_pre) begin
        acc <= '0;
        m   <= ~m;
      end else begin
        acc <= acc + AW'(1);
      end
    end
  end

  // R6: the bias output only moves on the end of a line pulse
  p_m_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!line_done && !clr) |=> (m == $past(m)));
endmodule

// File: rtl/lcd_timing_gen.sv
`timescale 1ns/1ps
module lcd_timing_gen #(
  parameter int PW = 6,
  parameter int AW = 5,
  parameter int XW = 10,
  parameter int YW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [PW-1:0] pix_pre,
  input  logic [AW-1:0] ac_pre,
  input  logic [XW-1:0] h_pixels,
  input  logic [YW-1:0] v_lines,
  output logic          pix_stb,
  output logic          line_pls,
  output logic          frame_pls,
  output logic          bias_m
);
  logic [PW-1:0] act_pre;
  logic [AW-1:0] act_ac;
  logic [XW-1:0] act_w;
  logic [YW-1:0] act_h;
  logic          stop, load, tick, stretch, line_done, frame_done;

  assign stop = !en || (act_pre == '0);
  assign load = stop || frame_done;

  // R7: configuration is captured only at a frame boundary or when idle
  always_ff @(posedge clk) begin
    if (rst) begin
      act_pre <= '0;
      act_ac  <= '0;
      act_w   <= '0;
      act_h   <= '0;
    end else if (load) begin
      act_pre <= pix_pre;
      act_ac  <= ac_pre;
      act_w   <= h_pixels;
      act_h   <= v_lines;
    end
  end

  lcd_pix_div #(.PW(PW)) u_div (
    .clk(clk), .rst(rst), .clr(stop), .pre(act_pre),
    .stretch(stretch), .tick(tick)
  );

  lcd_raster #(.XW(XW), .YW(YW)) u_raster (
    .clk(clk), .rst(rst), .clr(stop), .tick(tick),
    .width(act_w), .height(act_h),
    .pix_stb(pix_stb), .line_pls(line_pls), .frame_pls(frame_pls),
    .stretch(stretch), .line_done(line_done), .frame_done(frame_done)
  );

  lcd_bias #(.AW(AW)) u_bias (
    .clk(clk), .rst(rst), .clr(stop), .line_done(line_done),
    .ac_pre(act_ac), .m(bias_m)
  );

  // R2: a zero prescale yields no strobe
  p_no_stb_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (en && act_pre == '0) |=> !pix_stb);
  // R8: disabling clears every output on the next cycle
  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pix_stb && !line_pls && !frame_pls && !bias_m));
endmodule

// File: tb/tb_lcd_timing_gen.sv
`timescale 1ns/1ps
module tb_lcd_timing_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [5:0] pix_pre = '0;
  logic [4:0] ac_pre = '0;
  logic [9:0] h_pixels = 10'd1;
  logic [8:0] v_lines = 9'd1;
  logic       pix_stb, line_pls, frame_pls, bias_m;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  lcd_timing_gen dut (
    .clk(clk), .rst(rst), .en(en), .pix_pre(pix_pre), .ac_pre(ac_pre),
    .h_pixels(h_pixels), .v_lines(v_lines),
    .pix_stb(pix_stb), .line_pls(line_pls), .frame_pls(frame_pls), .bias_m(bias_m)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Runs the raster and checks strobe spacing, line/frame pulses and bias toggles.
  task automatic watch(input int n0, input int n1, input int chg_at, input int nac,
                       input int w, input int h, input int ncyc);
    int nexp = n0, last_stb = 0, rise_t = 0, fall_t = 0, stb_cnt = 0;
    int line_idx = 0, lines_m = 0;
    bit first = 1, pend = 0, chg_pend = 0, prev_line = 0, prev_m = 0;
    en = 1'b0;
    pix_pre = 6'(n0); ac_pre = 5'(nac); h_pixels = 10'(w); v_lines = 9'(h);
    repeat (3) @(negedge clk);
    en = 1'b1;
    for (int cyc = 1; cyc <= ncyc; cyc++) begin
      @(negedge clk);
      if (pix_stb) begin
        stb_cnt++;
        if (first)
          chk(cyc == n0 + 1, "R8 first strobe delay", cyc, n0 + 1);
        else if (!pend)
          chk(cyc - last_stb == nexp + 1, "R1 strobe spacing", cyc - last_stb, nexp + 1);
        else
          chk(cyc - fall_t == nexp + 1 + (nexp + 1) / 2, "R3 stretched first pixel",
              cyc - fall_t, nexp + 1 + (nexp + 1) / 2);
        first = 0; pend = 0; last_stb = cyc;
      end
      if (line_pls && !prev_line) begin
        chk(pix_stb, "R4 line rises with last strobe", int'(pix_stb), 1);
        chk(stb_cnt == w, "R4 strobes per line", stb_cnt, w);
        chk(frame_pls == (line_idx % h == 0), "R5 frame marker", int'(frame_pls),
            int'(line_idx % h == 0));
        stb_cnt = 0; rise_t = cyc; lines_m++;
      end
      if (!line_pls && prev_line) begin
        chk(cyc - rise_t == nexp + 1, "R4 line pulse length", cyc - rise_t, nexp + 1);
        if (line_idx % h == h - 1 && chg_pend) nexp = n1; // R7 frame-boundary switch
        line_idx++; fall_t = cyc; pend = 1;
      end
      if (frame_pls && !line_pls)
        chk(0, "R5 frame outside line", 1, 0);
      if (bias_m != prev_m) begin
        chk(lines_m == nac + 1, "R6 bias toggle period", lines_m, nac + 1);
        chk(!line_pls && prev_line, "R6 toggle at line end", int'(line_pls), 0);
        lines_m = 0;
      end
      prev_line = line_pls; prev_m = bias_m;
      if (cyc == chg_at) begin
        pix_pre = 6'(n1);
        chg_pend = 1;
      end
    end
    en = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!pix_stb && !line_pls && !frame_pls && !bias_m, "R8 reset outputs",
        int'({pix_stb, line_pls, frame_pls, bias_m}), 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_basic();
    watch(2, 2, -1, 3, 4, 3, 400);
    watch(5, 5, -1, 1, 3, 2, 400);
    watch(1, 1, -1, 2, 1, 1, 200);
    watch(63, 63, -1, 0, 2, 2, 1200);
  endtask

  task automatic t_bias();
    watch(1, 1, -1, 0, 2, 5, 300);
    watch(1, 1, -1, 1, 2, 5, 300);
    watch(1, 1, -1, 4, 2, 5, 400);
    watch(1, 1, -1, 13, 2, 5, 700);
  endtask

  task automatic t_change();
    // R7: new prescale written mid-frame applies from the next frame only
    watch(2, 4, 10, 2, 3, 2, 500);
  endtask

  task automatic t_zero();
    int seen = 0, first_t = 0;
    en = 1'b0; pix_pre = 6'd0; ac_pre = 5'd0; h_pixels = 10'd2; v_lines = 9'd2;
    repeat (2) @(negedge clk);
    en = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (pix_stb || line_pls || frame_pls) seen++;
    end
    chk(seen == 0, "R2 zero prescale silent", seen, 0);
    pix_pre = 6'd2;
    for (int cyc = 1; cyc <= 20; cyc++) begin
      @(negedge clk);
      if (pix_stb && first_t == 0) first_t = cyc;
    end
    chk(first_t == 4, "R2 restart delay", first_t, 4);
    en = 1'b0;
    @(negedge clk);
    chk(!pix_stb && !line_pls && !frame_pls && !bias_m, "R8 disable clears outputs",
        int'({pix_stb, line_pls, frame_pls, bias_m}), 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_bias();
    t_change();
    t_zero();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule